// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic and logic unit. It is built from identical one-bit slices whose carries are chained in series from bit 0 to the top bit. Each slice can complement its A bit and its B bit. It then selects one of four values: the AND of the two bits, the OR of the two bits, the full-adder sum, or a "less" input. NAND and NOR need no gates of their own: they reuse the OR and AND paths with both operands complemented.

A four-bit control word `{inv_a, neg_b, sel[1:0]}` picks the operation. Subtraction complements B and uses `neg_b` as the carry into bit 0, which gives the two's-complement of B. Set-on-less-than runs the same subtraction. It returns the corrected sign of the difference in bit 0 and zeros in every other bit. Equality is tested by subtracting and observing the `is_zero` output.

Top module: `alu_ripple`

## Requirements
- R1: Control word 0_0_00 (inv_a, neg_b, sel) gives res = opa AND opb.
- R2: Control word 0_0_01 gives res = opa OR opb.
- R3: Control word 0_0_10 gives res = (opa + opb) mod 2^W, and cout is the carry out of the top bit.
- R4: Control word 0_1_10 gives res = (opa - opb) mod 2^W, and cout is 1 exactly when opa >= opb taken as unsigned numbers (no borrow).
- R5: Control word 1_1_00 gives res = NOT(opa OR opb).
- R6: Control word 1_1_01 gives res = NOT(opa AND opb).
- R7: Control word 0_1_11 gives res bit 0 = 1 when opa < opb as signed two's-complement values, and all other bits 0. The result stays correct when the internal subtraction overflows.
- R8: For add and subtract, ovf is 1 exactly when the signed result does not fit in W bits.
- R9: is_zero is 1 exactly when every bit of res is 0 under every control word, so subtraction with is_zero = 1 signals opa == opb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W (32) | Operand A |
| opb | input | W (32) | Operand B |
| inv_a | input | 1 | Complement A in every slice |
| neg_b | input | 1 | Complement B in every slice; also the carry into bit 0 |
| sel | input | 2 | Slice output select: 00 AND, 01 OR, 10 sum, 11 less |
| res | output | W (32) | Result word |
| cout | output | 1 | Carry out of the top slice |
| ovf | output | 1 | Signed overflow of the top slice |
| is_zero | output | 1 | High when res is all zeros |

## Verification
All seven control words are applied to every pair drawn from the corner set 0, 1, all-ones, 0x80000000 and 0x7FFFFFFF. These pairs expose the full-length carry ripple, the borrow on subtraction and the two signed overflow directions. The SLT cases in this set, such as 0x80000000 against 0x7FFFFFFF, separate a comparison that uses the corrected sign from one that uses the raw sign. Random operand pairs then cover general bit mixes. Equal-operand subtractions make is_zero high, and near-equal ones show that a single differing bit clears it. Expected values come from integer arithmetic in the bench.

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         inv_a,
  input  logic         neg_b,
  input  logic [1:0]   sel,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf,
  output logic         is_zero
);

  logic [W:0] carry;
  logic       sum_msb;
  logic       set_less;

  assign carry[0] = neg_b;

  for (genvar i = 0; i < W; i++) begin : g_slice
    logic a_s, b_s, s_and, s_or, s_sum, s_less;
    assign a_s    = opa[i] ^ inv_a;
    assign b_s    = opb[i] ^ neg_b;
    assign s_and  = a_s & b_s;
    assign s_or   = a_s | b_s;
    assign s_sum  = a_s ^ b_s ^ carry[i];
    assign carry[i+1] = s_and | (a_s & carry[i]) | (b_s & carry[i]);
    if (i == 0) begin : g_lsb
      assign s_less = set_less;
    end else begin : g_upper
      assign s_less = 1'b0;
    end
    if (i == W-1) begin : g_msb
      assign sum_msb = s_sum;
    end
    always_comb begin
      case (sel)
        2'b00:   res[i] = s_and;
        2'b01:   res[i] = s_or;
        2'b10:   res[i] = s_sum;
        default: res[i] = s_less;
      endcase
    end
  end

  assign ovf      = carry[W-1] ^ carry[W];
  assign set_less = sum_msb ^ ovf;
  assign cout     = carry[W];
  assign is_zero  = ~|res;

endmodule

// File: rtl/alu_ripple_chk.sv
module alu_ripple_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         inv_a,
  input logic         neg_b,
  input logic [1:0]   sel,
  input logic [W-1:0] res,
  input logic         cout,
  input logic         ovf,
  input logic         is_zero
);

  logic [3:0] code;
  assign code = {inv_a, neg_b, sel};

  always_comb begin
    if (code == 4'b0000) a_r1_and: assert (res == (opa & opb)) else $error("R1 AND mismatch");
    if (code == 4'b0001) a_r2_or: assert (res == (opa | opb)) else $error("R2 OR mismatch");
    if (code == 4'b0010) a_r3_add: assert ({cout, res} == ({1'b0, opa} + {1'b0, opb})) else $error("R3 ADD mismatch");
    if (code == 4'b0110) a_r4_sub: assert (res == opa - opb && cout == (opa >= opb)) else $error("R4 SUB mismatch");
    if (code == 4'b1100) a_r5_nor: assert (res == ~(opa | opb)) else $error("R5 NOR mismatch");
    if (code == 4'b1101) a_r6_nand: assert (res == ~(opa & opb)) else $error("R6 NAND mismatch");
    if (code == 4'b0111) a_r7_slt: assert (res == {{(W-1){1'b0}}, ($signed(opa) < $signed(opb))}) else $error("R7 SLT mismatch");
    if (code == 4'b0010) a_r8_add_overflow: assert (ovf == ((opa[W-1] == opb[W-1]) && (res[W-1] != opa[W-1]))) else $error("R8 add overflow");
    if (code == 4'b0110) a_r8_sub_overflow: assert (ovf == ((opa[W-1] != opb[W-1]) && (res[W-1] != opa[W-1]))) else $error("R8 sub overflow");
    if (code == 4'b0110) a_r9_equal: assert (is_zero == (opa == opb)) else $error("R9 equality");
  end

endmodule

bind alu_ripple alu_ripple_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .inv_a(inv_a), .neg_b(neg_b), .sel(sel),
  .res(res), .cout(cout), .ovf(ovf), .is_zero(is_zero)
);

// File: tb/alu_ripple_test.sv
module alu_ripple_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa, opb;
  logic         inv_a, neg_b;
  logic [1:0]   sel;
  logic [W-1:0] res;
  logic         cout, ovf, is_zero;

  int vectors = 0;
  int misses  = 0;

  always #4 clk = ~clk;

  alu_ripple #(.W(W)) uut (
    .opa(opa), .opb(opb), .inv_a(inv_a), .neg_b(neg_b), .sel(sel),
    .res(res), .cout(cout), .ovf(ovf), .is_zero(is_zero)
  );

  localparam logic [3:0] CODES [7] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110,
                                       4'b1100, 4'b1101, 4'b0111};
  localparam logic [W-1:0] CORNER [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF,
                                          32'h8000_0000, 32'h7FFF_FFFF};

  function automatic string tag(input logic [3:0] c);
    case (c)
      4'b0000: return "R1 AND";
      4'b0001: return "R2 OR";
      4'b0010: return "R3 ADD";
      4'b0110: return "R4 SUB";
      4'b1100: return "R5 NOR";
      4'b1101: return "R6 NAND";
      default: return "R7 SLT";
    endcase
  endfunction

  task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] exp_r;
    logic [W:0]   wide;
    logic         exp_c, exp_v, chk_cv;
    @(negedge clk);
    {inv_a, neg_b, sel} = c;
    opa = a;
    opb = b;
    exp_c = 1'b0; exp_v = 1'b0; chk_cv = 1'b0;
    case (c)
      4'b0000: exp_r = a & b;
      4'b0001: exp_r = a | b;
      4'b0010: begin
        wide = {1'b0, a} + {1'b0, b};
        exp_r = wide[W-1:0]; exp_c = wide[W]; chk_cv = 1'b1;
        exp_v = (a[W-1] == b[W-1]) && (exp_r[W-1] != a[W-1]);
      end
      4'b0110: begin
        exp_r = a - b; exp_c = (a >= b); chk_cv = 1'b1;
        exp_v = (a[W-1] != b[W-1]) && (exp_r[W-1] != a[W-1]);
      end
      4'b1100: exp_r = ~(a | b);
      4'b1101: exp_r = ~(a & b);
      default: exp_r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
    endcase
    #2;
    vectors++;
    if (res !== exp_r) begin
      misses++;
      $display("FAIL %s a=%h b=%h res=%h expected %h", tag(c), a, b, res, exp_r);
    end else if (is_zero !== (exp_r == '0)) begin
      misses++;
      $display("FAIL R9 zero a=%h b=%h is_zero=%b expected %b", a, b, is_zero, exp_r == '0);
    end else if (chk_cv && cout !== exp_c) begin
      misses++;
      $display("FAIL %s carry a=%h b=%h cout=%b expected %b", tag(c), a, b, cout, exp_c);
    end else if (chk_cv && ovf !== exp_v) begin
      misses++;
      $display("FAIL R8 overflow a=%h b=%h ovf=%b expected %b", a, b, ovf, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    opa = '0; opb = '0; {inv_a, neg_b, sel} = 4'b0000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    apply(4'b0000, '0, '0);
    for (int k = 0; k < 7; k++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply(CODES[k], CORNER[i], CORNER[j]);
    for (int k = 0; k < 7; k++)
      for (int n = 0; n < 400; n++) begin
        logic [W-1:0] ra, rb;
        ra = $urandom;
        rb = (n % 4 == 0) ? ra : ((n % 4 == 1) ? ra ^ (32'h1 << (n % W)) : $urandom);
        apply(CODES[k], ra, rb);
      end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule